// File: doc/BRIEF.md
# Auto-Increment Register Stream Controller

This block sits behind a byte-wide serial slave front end and turns a stream of byte transfers into register accesses. A transaction opens with a start strobe that carries a register address. Each later read or write strobe moves one byte. For each byte the controller decides which location is targeted. Ordinary registers are single bytes. For those, the address steps forward after every byte, so one burst covers a run of neighbouring registers.

A fixed set of addresses does not advance. Four multibyte registers keep the address and step a byte position through their own storage instead. Their lengths are 0x29 with 5 bytes, 0x2D with 4, 0x4F with 4 and 0x7F with 8. Two further addresses serve an indirect bank of 200 bytes. Address 0x60 holds the bank index. Address 0x61 is the data port, and each byte through it uses the location at the current index and then moves the index on by one. Bank byte 0 is a flag byte, and only its low five bits are kept. Ordinary registers are a plain array of 256 bytes.

Top module: `reg_stream_ctrl`

## Requirements
- R1: A byte access to an ordinary address targets that address and then advances the address by one, wrapping from 0xFF to 0x00; a two-byte read from 0x00 returns registers 0x00 then 0x01.
- R2: At 0x29 (5 bytes), 0x2D (4), 0x4F (4) and 0x7F (8) the address holds, and each byte steps a byte position 0,1,2,… that wraps to 0 after the last byte. A burst that advances onto one of these addresses enters it at position 0.
- R3: The byte position returns to 0 at every transaction start.
- R4: The first read of a multibyte register in a transaction latches all of its bytes. Later reads in the same transaction return the latched bytes, even if a byte is written in between.
- R5: Address 0x60 reads and writes the bank index and never advances the address.
- R6: A write of 200 or more to 0x60 sets the index to 199.
- R7: Each byte read or written at 0x61 uses bank[index] and then raises the index by one. The address stays at 0x61.
- R8: An index step from 199 stays at 199.
- R9: Bank byte 0 stores only bits 4:0, and bits 7:5 read as 0.
- R10: Byte strobes are ignored in these cases: outside a transaction, in the cycle of a start strobe, and in the cycle of an end strobe.
- R11: Read data appears on rd_data_o on the clock edge that takes the read strobe and holds until the next accepted read. When read and write strobes come together, only the write is done.
- R12: After reset every storage byte is 0, the index is 0 and rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start_i | input | 1 | Opens a transaction at txn_addr_i |
| txn_addr_i | input | 8 | Start register address |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Write byte |
| rd_en_i | input | 1 | Byte read strobe |
| rd_data_o | output | 8 | Registered read byte |
| txn_end_i | input | 1 | Closes the transaction |

## Verification
The bench drives bursts in several situations: bursts that run into a multibyte register from a plain neighbour, bursts that wrap past the last byte position, and bursts that write between snapshot reads. A design that advanced on sticky addresses would spill data into 0x2A. A design that skipped the snapshot would return the newly written byte. The index is pushed to 198 and then streamed past the end, and it is also written with 250. A wrapping or unclamped index would corrupt bank byte 0 or read back the raw value. Strobes in start cycles, in end cycles and outside transactions are sent as well, so that a controller which accepts them shows a changed register.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int POS_W      = 3;
    localparam int MB_MAX     = 8;
    localparam int MB_TOTAL   = 21;
    localparam int MB_OFS_W   = 5;
    localparam int BANK_DEPTH = 200;
    localparam int IDX_W      = 8;
    localparam int FLAG_BITS  = 5;

    localparam logic [ADDR_W-1:0] IDX_ADDR  = 8'h60;
    localparam logic [ADDR_W-1:0] PORT_ADDR = 8'h61;

    typedef enum logic [1:0] {TGT_PLAIN, TGT_MB, TGT_IDX, TGT_PORT} tgt_e;

    // length in bytes of a multibyte register, zero for all others
    function automatic logic [POS_W:0] mb_len(input logic [ADDR_W-1:0] a);
        case (a)
            8'h29:   mb_len = 4'd5;
            8'h2D:   mb_len = 4'd4;
            8'h4F:   mb_len = 4'd4;
            8'h7F:   mb_len = 4'd8;
            default: mb_len = 4'd0;
        endcase
    endfunction

    // first byte of each multibyte register in the shared storage
    function automatic logic [MB_OFS_W-1:0] mb_base(input logic [ADDR_W-1:0] a);
        case (a)
            8'h2D:   mb_base = 5'd5;
            8'h4F:   mb_base = 5'd9;
            8'h7F:   mb_base = 5'd13;
            default: mb_base = 5'd0;
        endcase
    endfunction

    function automatic tgt_e decode(input logic [ADDR_W-1:0] a);
        if (a == IDX_ADDR)        decode = TGT_IDX;
        else if (a == PORT_ADDR)  decode = TGT_PORT;
        else if (mb_len(a) != '0) decode = TGT_MB;
        else                      decode = TGT_PLAIN;
    endfunction
endpackage

// File: rtl/rsc_seq.sv
module rsc_seq
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              end_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [POS_W-1:0]  pos_o,
    output tgt_e              tgt_o,
    output logic              wr_go_o,
    output logic              rd_go_o
);
    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  pos;
    } seq_t;

    seq_t         seq_q, seq_d;
    logic         go;
    tgt_e         tgt;
    logic [POS_W:0] pos_nx;

    always_comb begin
        seq_d  = seq_q;
        tgt    = decode(seq_q.addr);
        go     = seq_q.active & ~start_i & ~end_i & (wr_i | rd_i);
        pos_nx = {1'b0, seq_q.pos} + 1'b1;
        if (start_i) begin
            seq_d.active = 1'b1;
            seq_d.addr   = start_addr_i;
            seq_d.pos    = '0;
        end else if (end_i) begin
            seq_d.active = 1'b0;
        end else if (go) begin
            unique case (tgt)
                TGT_PLAIN: seq_d.addr = seq_q.addr + 1'b1;
                TGT_MB:    seq_d.pos  = (pos_nx == mb_len(seq_q.addr)) ? '0
                                                                       : pos_nx[POS_W-1:0];
                default:   seq_d.addr = seq_q.addr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign addr_o  = seq_q.addr;
    assign pos_o   = seq_q.pos;
    assign tgt_o   = tgt;
    assign wr_go_o = go & wr_i;
    assign rd_go_o = go & ~wr_i & rd_i;

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (addr_o == $past(start_addr_i) && pos_o == '0));

    // R1
    plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && tgt == TGT_PLAIN) |=> (addr_o == $past(addr_o) + 1'b1));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && tgt != TGT_PLAIN) |=> $stable(addr_o));

    // R2
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_MB) |-> ({1'b0, pos_o} < mb_len(addr_o)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.active && !start_i) |=> ($stable(addr_o) && $stable(pos_o)));
endmodule

// File: rtl/rsc_plain.sv
module rsc_plain
    import rsc_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } plain_t;

    plain_t         st_q, st_d;
    logic [AW-1:0]  sel;

    assign sel = addr_i[AW-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.mem[sel] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.mem[sel];

    // R1
    plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.mem[$past(sel)] == $past(wdata_i)));
endmodule

// File: rtl/rsc_mbreg.sv
module rsc_mbreg
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [MB_TOTAL-1:0][DATA_W-1:0] mem;
        logic [MB_MAX-1:0][DATA_W-1:0]   snap;
        logic                            snap_vld;
    } mb_t;

    mb_t                 st_q, st_d;
    logic [MB_OFS_W-1:0] base;
    logic [MB_OFS_W-1:0] ofs;

    assign base = mb_base(addr_i);
    assign ofs  = base + MB_OFS_W'(pos_i);

    always_comb begin : next_state
        logic [MB_OFS_W:0] src;
        st_d = st_q;
        src  = '0;
        if (start_i) st_d.snap_vld = 1'b0;
        if (wr_i) st_d.mem[ofs] = wdata_i;
        if (rd_i && !st_q.snap_vld) begin
            for (int k = 0; k < MB_MAX; k++) begin
                src = {1'b0, base} + (MB_OFS_W+1)'(k);
                st_d.snap[k] = (src < (MB_OFS_W+1)'(MB_TOTAL))
                             ? st_q.mem[src[MB_OFS_W-1:0]] : '0;
            end
            st_d.snap_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.snap_vld ? st_q.snap[pos_i] : st_q.mem[ofs];

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.snap_vld && !start_i) |=> $stable(st_q.snap));

    // R4
    snap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !st_q.snap_vld);

    // R2
    mb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.mem[$past(ofs)] == $past(wdata_i)));
endmodule

// File: rtl/rsc_bank.sv
module rsc_bank
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr_i,
    input  logic              port_wr_i,
    input  logic              port_rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [IDX_W-1:0]  LAST      = IDX_W'(BANK_DEPTH - 1);
    localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'((1 << FLAG_BITS) - 1);

    typedef struct packed {
        logic [BANK_DEPTH-1:0][DATA_W-1:0] mem;
        logic [IDX_W-1:0]                  idx;
    } bank_t;

    bank_t st_q, st_d;
    logic  port_go;

    assign port_go = port_wr_i | port_rd_i;

    always_comb begin
        st_d = st_q;
        if (idx_wr_i) begin
            st_d.idx = (IDX_W'(wdata_i) > LAST) ? LAST : IDX_W'(wdata_i);
        end else if (port_go) begin
            if (port_wr_i) begin
                st_d.mem[st_q.idx] = (st_q.idx == '0) ? (wdata_i & FLAG_MASK) : wdata_i;
            end
            st_d.idx = (st_q.idx == LAST) ? LAST : st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_o   = st_q.idx;
    assign rdata_o = st_q.mem[st_q.idx];

    // R6
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr_i && IDX_W'(wdata_i) > LAST) |=> (idx_o == LAST));

    // R7
    port_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_go && !idx_wr_i && idx_o != LAST) |=> (idx_o == $past(idx_o) + 1'b1));

    // R8
    port_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_go && !idx_wr_i && idx_o == LAST) |=> (idx_o == LAST));

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_o <= LAST);

    // R9
    flag_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mem[0][DATA_W-1:FLAG_BITS] == '0);
endmodule

// File: rtl/reg_stream_ctrl.sv
module reg_stream_ctrl
    import rsc_pkg::*;
#(
    parameter int PLAIN_DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start_i,
    input  logic [7:0] txn_addr_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_en_i,
    output logic [7:0] rd_data_o,
    input  logic       txn_end_i
);
    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } top_t;

    top_t              out_q, out_d;
    logic [ADDR_W-1:0] cur_addr;
    logic [POS_W-1:0]  cur_pos;
    tgt_e              tgt;
    logic              wr_go, rd_go;
    logic [DATA_W-1:0] plain_rd, mb_rd, bank_rd;
    logic [IDX_W-1:0]  bank_idx;

    rsc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (txn_start_i),
        .start_addr_i (txn_addr_i),
        .end_i        (txn_end_i),
        .wr_i         (wr_en_i),
        .rd_i         (rd_en_i),
        .addr_o       (cur_addr),
        .pos_o        (cur_pos),
        .tgt_o        (tgt),
        .wr_go_o      (wr_go),
        .rd_go_o      (rd_go)
    );

    rsc_plain #(.DEPTH(PLAIN_DEPTH)) u_plain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_go && tgt == TGT_PLAIN),
        .addr_i  (cur_addr),
        .wdata_i (wr_data_i),
        .rdata_o (plain_rd)
    );

    rsc_mbreg u_mb (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (txn_start_i),
        .wr_i    (wr_go && tgt == TGT_MB),
        .rd_i    (rd_go && tgt == TGT_MB),
        .addr_i  (cur_addr),
        .pos_i   (cur_pos),
        .wdata_i (wr_data_i),
        .rdata_o (mb_rd)
    );

    rsc_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr_i  (wr_go && tgt == TGT_IDX),
        .port_wr_i (wr_go && tgt == TGT_PORT),
        .port_rd_i (rd_go && tgt == TGT_PORT),
        .wdata_i   (wr_data_i),
        .idx_o     (bank_idx),
        .rdata_o   (bank_rd)
    );

    always_comb begin
        out_d = out_q;
        if (rd_go) begin
            unique case (tgt)
                TGT_PLAIN: out_d.rd = plain_rd;
                TGT_MB:    out_d.rd = mb_rd;
                TGT_IDX:   out_d.rd = DATA_W'(bank_idx);
                TGT_PORT:  out_d.rd = bank_rd;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data_o = out_q.rd;

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data_o));

    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rd_en_i) |=> $stable(rd_data_o));
endmodule

// File: tb/sim_reg_stream_ctrl.sv
`timescale 1ns/1ps
module sim_reg_stream_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       txn_start_i, wr_en_i, rd_en_i, txn_end_i;
    logic [7:0] txn_addr_i, wr_data_i, rd_data_o;

    always #2.5 clk = ~clk;

    reg_stream_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start_i (txn_start_i),
        .txn_addr_i  (txn_addr_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .rd_en_i     (rd_en_i),
        .rd_data_o   (rd_data_o),
        .txn_end_i   (txn_end_i)
    );

    int    plain [256];
    int    mbm   [256][8];
    int    bank  [200];
    int    snap  [8];
    int    idx, caddr, pos, exp_rd;
    bit    active, snapv, done;
    int    checks, fails;
    string req;

    function automatic int mblen(int a);
        case (a)
            'h29: return 5;
            'h2D: return 4;
            'h4F: return 4;
            'h7F: return 8;
            'h60, 'h61: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic model(bit st, int a, bit w, int wd, bit r, bit e);
        if (st) begin
            caddr = a; pos = 0; active = 1; snapv = 0;
        end else if (e) begin
            active = 0;
        end else if (active && (w || r)) begin
            if (w) begin
                if (caddr == 'h60) idx = (wd > 199) ? 199 : wd;
                else if (caddr == 'h61) begin
                    bank[idx] = (idx == 0) ? (wd & 31) : wd;
                    if (idx < 199) idx++;
                end else if (mblen(caddr) > 0) mbm[caddr][pos] = wd;
                else plain[caddr] = wd;
            end else begin
                if (caddr == 'h60) exp_rd = idx;
                else if (caddr == 'h61) begin
                    exp_rd = bank[idx];
                    if (idx < 199) idx++;
                end else if (mblen(caddr) > 0) begin
                    if (!snapv) begin
                        for (int k = 0; k < 8; k++) snap[k] = mbm[caddr][k];
                        snapv = 1;
                    end
                    exp_rd = snap[pos];
                end else exp_rd = plain[caddr];
            end
            if (mblen(caddr) > 0) pos = (pos + 1) % mblen(caddr);
            else caddr = (caddr + 1) % 256;
        end
    endtask

    task automatic check(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(bit st, int a, bit w, int wd, bit r, bit e);
        txn_start_i = st; txn_addr_i = 8'(a);
        wr_en_i = w; wr_data_i = 8'(wd);
        rd_en_i = r; txn_end_i = e;
        @(posedge clk);
        model(st, a, w, wd, r, e);
        @(negedge clk);
        check(int'(rd_data_o), exp_rd, req);
    endtask

    task automatic go(int a);   step(1, a, 0, 0, 0, 0); endtask
    task automatic wb(int d);   step(0, 0, 1, d, 0, 0); endtask
    task automatic rb();        step(0, 0, 0, 0, 1, 0); endtask
    task automatic fin();       step(0, 0, 0, 0, 0, 1); endtask
    task automatic expect_rd(int v, string tag); check(int'(rd_data_o), v, tag); endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        txn_start_i = 0; txn_addr_i = 0; wr_en_i = 0; wr_data_i = 0;
        rd_en_i = 0; txn_end_i = 0; rst_n = 0;
        idx = 0; caddr = 0; pos = 0; exp_rd = 0; active = 0; snapv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        req = "R12";
        check(int'(rd_data_o), 0, "R12 reset read data");
        go('h60); rb(); expect_rd(0, "R12 index reset"); fin();
        go('h7F); rb(); expect_rd(0, "R12 multibyte reset"); fin();

        req = "R1";
        go('h00); wb('h11); wb('h22); wb('h33); fin();
        go('h00); rb(); expect_rd('h11, "R1 first"); rb(); expect_rd('h22, "R1 second"); fin();
        go('hFE); wb('hA1); wb('hA2); wb('hA3); fin();
        go('h00); rb(); expect_rd('hA3, "R1 wrap"); fin();

        req = "R2";
        go('h29); for (int i = 1; i <= 6; i++) wb(i); fin();
        go('h29); rb(); expect_rd(6, "R2 wrapped write");
        rb(); expect_rd(2, "R2 pos1"); rb(); rb(); rb(); expect_rd(5, "R2 last");
        rb(); expect_rd(6, "R2 wrap read"); fin();
        go('h28); wb('h77); wb('h88); fin();
        go('h29); rb(); expect_rd('h88, "R2 entry at pos0"); fin();
        go('h2A); rb(); expect_rd(0, "R2 neighbour untouched"); fin();

        req = "R3";
        go('h2D); wb(9); wb(8); fin();
        go('h2D); wb(7); fin();
        go('h2D); rb(); expect_rd(7, "R3 pos reset"); rb(); expect_rd(8, "R3 pos1"); fin();

        req = "R4";
        go('h4F); wb(1); wb(2); wb(3); wb(4); fin();
        go('h4F); rb(); expect_rd(1, "R4 first");
        wb('h55); rb(); expect_rd(3, "R4 p2"); rb(); rb(); expect_rd(1, "R4 p0");
        rb(); expect_rd(2, "R4 snapshot kept"); fin();
        go('h4F); rb(); rb(); expect_rd('h55, "R4 new data next txn"); fin();

        req = "R5";
        go('h60); wb(5); wb(7); fin();
        go('h60); rb(); expect_rd(7, "R5 index rw"); rb(); expect_rd(7, "R5 no advance"); fin();

        req = "R6";
        go('h60); wb(250); rb(); expect_rd(199, "R6 clamp 250");
        wb(200); rb(); expect_rd(199, "R6 clamp 200"); fin();

        req = "R7";
        go('h60); wb(10); fin();
        go('h61); wb('hA0); wb('hA1); wb('hA2); fin();
        go('h60); rb(); expect_rd(13, "R7 index advanced"); fin();
        go('h60); wb(10); fin();
        go('h61); rb(); expect_rd('hA0, "R7 port0"); rb(); rb(); expect_rd('hA2, "R7 port2"); fin();

        req = "R8";
        go('h60); wb(198); fin();
        go('h61); wb('h31); wb('h32); wb('h33); fin();
        go('h60); rb(); expect_rd(199, "R8 saturate"); fin();
        go('h60); wb(198); fin();
        go('h61); rb(); expect_rd('h31, "R8 198"); rb(); expect_rd('h33, "R8 199");
        rb(); expect_rd('h33, "R8 held"); fin();
        go('h00); rb(); expect_rd('hA3, "R8 no wrap into plain"); fin();

        req = "R9";
        go('h60); wb(0); fin();
        go('h61); wb('hFF); fin();
        go('h60); wb(0); fin();
        go('h61); rb(); expect_rd('h1F, "R9 flag byte"); fin();

        req = "R10";
        go('h10); fin();
        wb('h99);
        step(1, 'h10, 1, 'h44, 0, 0);
        step(0, 0, 1, 'h55, 0, 1);
        go('h10); rb(); expect_rd(0, "R10 ignored strobes"); fin();
        go('h00); rb(); fin();
        rb(); expect_rd('hA3, "R10 read outside holds");

        req = "R11";
        go('h20); step(0, 0, 1, 'h66, 1, 0); expect_rd('hA3, "R11 write wins hold");
        fin(); go('h20); rb(); expect_rd('h66, "R11 write done"); fin();
        step(0, 0, 0, 0, 0, 0); expect_rd('h66, "R11 idle hold");

        done = 1;
        summary();
        $finish;
    end
endmodule